// File: doc/BRIEF.md
# Prescaled Reload Countdown Timer

This block is a word-wide down-counter behind a small register bus. Software programs a reload value, a control word (run enable, automatic reload, and an 8-bit clock divider), and watches a sticky expiry flag. While it runs with a non-zero count, the counter steps down by one every (divider + 1) clock cycles. When a step takes it from one to zero, the expiry flag is set. The counter then either refills from the reload value and keeps going, or stays at zero and halts.

An interrupt line pulses high for exactly one cycle when the expiry flag changes from clear to set. A flag that is already set produces no further pulses until software clears it by writing a one to it. The bus is a single-cycle write strobe with a word index. Read data is combinational from the index, so it needs no read strobe. A parameter can add one register stage to the interrupt pulse. By default the pulse is high in the cycle right after the clock edge that sets the flag.

Top module: `cdt_timer`

## Requirements
- R1: After reset all four registers read 0 and `irq_o` is low.
- R2: Word index 0 is the reload value, 1 the count, 2 control and 3 the flag. In control, bit 0 is run enable, bit 1 is automatic reload and bits 15:8 are the divider P. Other control bits read back 0. The flag reads as bit 0 of index 3.
- R3: A write to index 0 stores the reload value and also places it in the counter. A write to index 1 changes only the counter.
- R4: While enabled with a non-zero count, the counter drops by one every P+1 cycles. The first drop comes P+1 cycles after the edge that wrote the count or set the enable.
- R5: When the count steps from 1 to 0 with automatic reload on, the flag is set and the counter takes the reload value and keeps running.
- R6: When the count steps from 1 to 0 with automatic reload off, the flag is set and the counter stays at 0.
- R7: Index 1 reads 0 while disabled or at zero. A disabled counter holds its value, which reads back once enable is set again.
- R8: If enable goes 0 to 1 in a write whose automatic reload bit is 1 while the count is 0, the counter is loaded from the reload value. With that bit at 0 it stays 0.
- R9: Writing index 3 clears the flag where bit 0 is 1. Writing 0 leaves the flag unchanged.
- R10: `irq_o` is high for one cycle when the flag goes from 0 to 1. It stays low while the flag stays set, including on later expiries.
- R11: Writes to indices 4 to 7 change no register, and reads of them return 0.
- R12: A count of 0 never decrements and never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | SEL_W (3) | Word index of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_sel` |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The assertions assume that the write strobe is only sampled at clock edges, and that a divider change in mid-count may shorten one period. The interrupt-pulse property assumes the default, unregistered interrupt stage. The stimulus drives every bus change half a cycle away from the active edge. It disables the counter before it reprograms the divider or reload, so every expected expiry cycle follows from N·(P+1) arithmetic. A sweep over divider, count and reload mode checks the read value and the interrupt line in every cycle through two reload periods.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   // Word indices decoded on the register bus
   localparam int IDX_LOAD  = 0;
   localparam int IDX_COUNT = 1;
   localparam int IDX_CTRL  = 2;
   localparam int IDX_FLAG  = 3;
   // Control word field positions
   localparam int CTL_EN    = 0;
   localparam int CTL_AUTO  = 1;
   localparam int CTL_PLSB  = 8;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
   parameter int DATA_W = 32,
   parameter int PRE_W  = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic [DATA_W-1:0] reload_q,
   output logic              en_q,
   output logic              auto_q,
   output logic [PRE_W-1:0]  div_q,
   output logic              flag_q,
   output logic              wr_count,
   output logic              en_rise,
   output logic              auto_wr,
   output logic [DATA_W-1:0] ctrl_rd
);
   import cdt_pkg::*;

   logic hit_load, hit_count, hit_ctrl, hit_flag;

   always_comb begin
      hit_load  = we && (sel == SEL_W'(IDX_LOAD));
      hit_count = we && (sel == SEL_W'(IDX_COUNT));
      hit_ctrl  = we && (sel == SEL_W'(IDX_CTRL));
      hit_flag  = we && (sel == SEL_W'(IDX_FLAG));
      wr_count  = hit_load || hit_count;
      en_rise   = hit_ctrl && !en_q && wdata[CTL_EN];
      auto_wr   = wdata[CTL_AUTO];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         en_q     <= 1'b0;
         auto_q   <= 1'b0;
         div_q    <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (hit_load) reload_q <= wdata;
         if (hit_ctrl) begin
            en_q   <= wdata[CTL_EN];
            auto_q <= wdata[CTL_AUTO];
            div_q  <= wdata[CTL_PLSB +: PRE_W];
         end
         if (expire)                     flag_q <= 1'b1;
         else if (hit_flag && wdata[0])  flag_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_rd                   = '0;
      ctrl_rd[CTL_EN]           = en_q;
      ctrl_rd[CTL_AUTO]         = auto_q;
      ctrl_rd[CTL_PLSB +: PRE_W] = div_q;
   end

   a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_flag && wdata[0] && !expire) |=> !flag_q);
   a_r9_keep_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(hit_flag && wdata[0])) |=> flag_q);
   a_r11_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel > SEL_W'(IDX_FLAG)) |=> ($stable(reload_q) && $stable(en_q)
                                          && $stable(auto_q) && $stable(div_q)));
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;

   // >= rather than == so a divider lowered mid-count still ticks
   assign tick = run && !restart && (pre_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pre_q <= '0;
      else if (!run || restart || tick) pre_q <= '0;
      else                            pre_q <= pre_q + PRE_W'(1);
   end

   a_r4_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pre_q == '0));
   a_r4_spaced_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_count,
   input  logic [DATA_W-1:0] wdata,
   input  logic              en_rise,
   input  logic              auto_wr,
   input  logic              auto_q,
   input  logic [DATA_W-1:0] reload_q,
   input  logic              tick,
   output logic [DATA_W-1:0] cnt_q,
   output logic              expire
);
   logic [DATA_W-1:0] cnt_d;
   logic              at_one;

   always_comb begin
      at_one = (cnt_q == DATA_W'(1));
      expire = tick && at_one && !wr_count;
      cnt_d  = cnt_q;
      if (wr_count)
         cnt_d = wdata;
      else if (en_rise && auto_wr && cnt_q == '0)
         cnt_d = reload_q;
      else if (tick)
         cnt_d = at_one ? (auto_q ? reload_q : '0) : cnt_q - DATA_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_count && cnt_q > DATA_W'(1)) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && auto_q) |=> (cnt_q == $past(reload_q)));
   a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !auto_q) |=> (cnt_q == '0));
   a_r12_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !wr_count && !en_rise) |=> (cnt_q == '0));
   a_r12_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> !expire);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
   parameter int DATA_W  = 32,
   parameter int PRE_W   = 8,
   parameter int SEL_W   = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [SEL_W-1:0]  bus_sel,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   import cdt_pkg::*;

   localparam int CTL_TOP = CTL_PLSB + PRE_W;

   if (DATA_W < CTL_TOP) begin : g_bad_width
      $error("cdt_timer: DATA_W too narrow for the divider field");
   end
   if (SEL_W < 2) begin : g_bad_sel
      $error("cdt_timer: SEL_W must cover four registers");
   end

   logic [DATA_W-1:0] reload_q, cnt_q, ctrl_rd;
   logic [PRE_W-1:0]  div_q;
   logic en_q, auto_q, flag_q, wr_count, en_rise, auto_wr, expire, tick, run;
   logic flag_d1;

   cdt_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .sel(bus_sel), .wdata(bus_wdata),
      .expire(expire), .reload_q(reload_q), .en_q(en_q), .auto_q(auto_q),
      .div_q(div_q), .flag_q(flag_q), .wr_count(wr_count), .en_rise(en_rise),
      .auto_wr(auto_wr), .ctrl_rd(ctrl_rd));

   assign run = en_q && (cnt_q != '0);

   cdt_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(wr_count || en_rise),
      .div(div_q), .tick(tick));

   cdt_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .wdata(bus_wdata),
      .en_rise(en_rise), .auto_wr(auto_wr), .auto_q(auto_q),
      .reload_q(reload_q), .tick(tick), .cnt_q(cnt_q), .expire(expire));

   always_comb begin
      bus_rdata = '0;
      if (bus_sel == SEL_W'(IDX_LOAD))       bus_rdata = reload_q;
      else if (bus_sel == SEL_W'(IDX_COUNT)) bus_rdata = run ? cnt_q : '0;
      else if (bus_sel == SEL_W'(IDX_CTRL))  bus_rdata = ctrl_rd;
      else if (bus_sel == SEL_W'(IDX_FLAG))  bus_rdata[0] = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_d1 <= 1'b0;
      else        flag_d1 <= flag_q;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_q && !flag_d1;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = flag_q && !flag_d1;
      a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (flag_q && $rose(flag_q)));
   end

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   a_r7_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && bus_sel == SEL_W'(IDX_COUNT)) |-> (bus_rdata == '0));
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_sel = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cdt_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int s, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 3'(s); bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input int s, output logic [31:0] v);
      @(negedge clk);
      bus_sel = 3'(s);
      #1 v = bus_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 4; i++) begin
         rd(i, v); chk("R1", v, 32'h0);
      end
      chk("R1 irq", {31'h0, irq_o}, 32'h0);
      // R2 control field layout
      wr(2, 32'hFFFF_FFFF);
      rd(2, v); chk("R2", v, 32'h0000_FF03);
      wr(2, 32'h0);
      // R3 reload write also sets count; count write leaves reload
      wr(0, 32'd9);
      rd(0, v); chk("R3 load", v, 32'd9);
      wr(1, 32'd4);
      rd(0, v); chk("R3 load kept", v, 32'd9);
      rd(1, v); chk("R7 disabled read", v, 32'h0);
      wr(2, 32'h1);
      rd(1, v); chk("R7 held count", v, 32'd4);
      repeat (6) @(posedge clk);
      rd(1, v); chk("R6 stopped", v, 32'h0);
      rd(3, v); chk("R6 flag", v, 32'h1);
      // R9 write-one-to-clear
      wr(3, 32'h0);
      rd(3, v); chk("R9 zero write", v, 32'h1);
      wr(3, 32'h1);
      rd(3, v); chk("R9 clear", v, 32'h0);
      // R8 / R12 enabling at zero count
      wr(2, 32'h0);
      wr(0, 32'd6);
      wr(1, 32'd0);
      wr(2, 32'h1);
      rd(1, v); chk("R8 no auto", v, 32'h0);
      repeat (4) @(posedge clk);
      rd(3, v); chk("R12 no expiry", v, 32'h0);
      wr(2, 32'h0);
      wr(2, 32'h3);
      rd(1, v); chk("R8 pulled reload", v, 32'd6);
      wr(2, 32'h0);
      // R11 undefined indices
      wr(5, 32'hFFFF_FFFF);
      wr(7, 32'h1234_5678);
      rd(0, v); chk("R11 load", v, 32'd6);
      rd(2, v); chk("R11 ctrl", v, 32'h0);
      rd(3, v); chk("R11 flag", v, 32'h0);
      rd(5, v); chk("R11 read", v, 32'h0);
      rd(6, v); chk("R11 read", v, 32'h0);
      // R4 R5 R6 R10 sweep of divider, count and reload mode
      for (int p = 0; p < 4; p++) begin
         for (int ni = 0; ni < 4; ni++) begin
            for (int a = 0; a < 2; a++) begin
               int n, t, m;
               logic [31:0] ctl, ec;
               n = (ni == 3) ? 5 : ni + 1;
               t = n * (p + 1);
               ctl = (32'(p) << 8) | (32'(a) << 1);
               wr(2, ctl);
               wr(3, 32'h1);
               wr(0, 32'(n));
               wr(2, ctl | 32'h1);
               bus_sel = 3'd1;
               for (int k = 1; k <= 2 * t + 1; k++) begin
                  @(posedge clk);
                  #2;
                  m = k / (p + 1);
                  if (a == 1) ec = 32'(n - (m % n));
                  else        ec = (m >= n) ? 32'h0 : 32'(n - m);
                  chk(a ? "R5/R4 count" : "R6/R4 count", bus_rdata, ec);
                  chk("R10 irq", {31'h0, irq_o}, (k == t) ? 32'h1 : 32'h0);
               end
            end
         end
      end
      wr(2, 32'h0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule